// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer Unit

This block is a standalone watchdog counter. Software controls it through three byte-wide registers, reached with a register index, 8-bit write data and separate write and read strobes. The count register is the watchdog itself. Writing a value from 1 to 255 arms the counter, and writing it again acts as the keep-alive. Writing 0 stops it. Reading the count register returns the time left, because the counter decrements in place.

An internal prescaler divides the system clock into one tick per second. In minute mode it gives one tick per sixty seconds. When the count steps from 1 to 0, the block sets a sticky expiry flag and drives an active-low reset pulse for a fixed number of clocks. After the pulse it stays stopped at zero. A control bit decides whether the same pulse also drives a keyboard-reset output. Keyboard and mouse activity inputs can reload the running count, and keyboard activity can optionally cancel the watchdog instead.

The sequencing is a three-state machine:
- IDLE: stopped, count zero.
- RUN: counting down.
- FIRE: reset pulse active.

Its transitions are:
- IDLE→RUN on a nonzero count write.
- RUN→IDLE on a zero write or a keyboard cancel.
- RUN→FIRE on expiry.
- FIRE→RUN or FIRE→IDLE at the end of the pulse, depending on whether software has written a nonzero count during the pulse.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, all three registers read 0, both reset outputs are high and the watchdog is stopped.
- R2: Register index 0 is the count, index 1 is control and index 2 is status. In control only bits 1, 2 and 3 are kept. In status only bits 4, 6 and 7 exist, and bit 4 cannot be set by a write. Index 3 reads 0.
- R3: Writing N (1..255) to the count arms the watchdog. The count then reads N and decreases by one every CLKS_PER_SEC clocks after the write.
- R4: Writing 0 to the count stops the watchdog: the count stays 0 and no reset pulse occurs.
- R5: Writing a nonzero count while running replaces the count and restarts the prescaler, so the next decrement comes a full unit after that write.
- R6: When the count steps from 1 to 0, status bit 4 is set and `wdt_rst_n` is low for exactly PULSE_LEN clocks. The count then stays 0 with the watchdog stopped.
- R7: Status bit 4 stays set until software writes the status register with bit 4 equal to 0. Writing it as 1 has no effect.
- R8: `kbrst_n` carries the same low pulse as `wdt_rst_n` only while control bit 1 is 1. Otherwise it stays high.
- R9: With control bit 3 set, one count unit lasts 60 seconds (60*CLKS_PER_SEC clocks).
- R10: While running, a keyboard pulse reloads the last armed count when status bit 6 is 1 and control bit 2 is 0. A mouse pulse reloads the count when status bit 7 is 1. With the enable bit 0, the pulse is ignored.
- R11: While running with control bit 2 set, a keyboard pulse stops the watchdog: the count becomes 0 and no pulse follows.
- R12: `rd_data` is 0 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 2 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, 0 when not reading |
| kbd_act | input | 1 | Keyboard activity pulse |
| mouse_act | input | 1 | Mouse activity pulse |
| wdt_rst_n | output | 1 | Active-low timeout reset pulse |
| kbrst_n | output | 1 | Active-low keyboard-reset output |

## Verification
The hardest situation to reach from the ports is the exact clock on which the count steps from 1 to 0. That clock depends on the prescaler phase, and every write or activity reload restarts the phase. The bench therefore always starts from a register write on a known edge and counts clocks from that edge. With the prescaler period shortened to four clocks, one-unit boundaries can be hit exactly, including the one-clock-early case. Minute mode runs with a count of 1, so its 240-clock boundary stays short.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    localparam int IDX_W = 2;
    localparam int DATA_W = 8;

    localparam logic [IDX_W-1:0] IDX_COUNT = 2'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 2'd1;
    localparam logic [IDX_W-1:0] IDX_STAT  = 2'd2;

    localparam int CTRL_KBRST_ROUTE = 1;
    localparam int CTRL_KBD_CANCEL  = 2;
    localparam int CTRL_MINUTES     = 3;

    localparam int STS_EXPIRED  = 4;
    localparam int STS_KBD_EN   = 6;
    localparam int STS_MOUSE_EN = 7;

    localparam logic [DATA_W-1:0] CTRL_MASK   = 8'h0E;
    localparam logic [DATA_W-1:0] STS_WR_MASK = 8'hC0;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CLKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic minutes,
    output logic unit_tick
);
    localparam int SUB_W = $clog2(CLKS_PER_SEC > 1 ? CLKS_PER_SEC : 2);
    localparam int MIN_W = $clog2(SECS_PER_MIN > 1 ? SECS_PER_MIN : 2);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(SECS_PER_MIN - 1);

    logic active;
    logic sec_tick;
    logic [MIN_W-1:0] min_q;

    assign active = run && !restart;

    generate
        if (CLKS_PER_SEC <= 1) begin : g_direct
            assign sec_tick = active;
        end else begin : g_divide
            localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLKS_PER_SEC - 1);
            logic [SUB_W-1:0] sub_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sub_q <= '0;
                end else if (!active) begin
                    sub_q <= '0;
                end else if (sub_q == SUB_LAST) begin
                    sub_q <= '0;
                end else begin
                    sub_q <= sub_q + 1'b1;
                end
            end

            assign sec_tick = active && (sub_q == SUB_LAST);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q <= '0;
        end else if (!active || !minutes) begin
            min_q <= '0;
        end else if (sec_tick) begin
            min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
        end
    end

    assign unit_tick = sec_tick && (!minutes || (min_q == MIN_LAST));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              expire_evt,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] sts_q
);
    logic ctrl_wr;
    logic sts_wr;
    logic expired_nxt;

    assign ctrl_wr = wr_en && (reg_idx == IDX_CTRL);
    assign sts_wr  = wr_en && (reg_idx == IDX_STAT);

    always_comb begin
        expired_nxt = sts_q[STS_EXPIRED];
        if (sts_wr && !wr_data[STS_EXPIRED]) begin
            expired_nxt = 1'b0;
        end
        if (expire_evt) begin
            expired_nxt = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data & CTRL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            if (sts_wr) begin
                sts_q[STS_KBD_EN]   <= wr_data[STS_KBD_EN];
                sts_q[STS_MOUSE_EN] <= wr_data[STS_MOUSE_EN];
            end
            sts_q[STS_EXPIRED] <= expired_nxt;
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              unit_tick,
    input  logic              act_reload,
    input  logic              act_cancel,
    output wd_state_e         state_q,
    output logic [DATA_W-1:0] count_q,
    output logic              expire_evt,
    output logic              presc_restart,
    output logic              pulse_on
);
    localparam int PC_W = $clog2(PULSE_LEN > 1 ? PULSE_LEN : 2);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_LEN - 1);

    wd_state_e         state_nxt;
    logic [DATA_W-1:0] count_nxt;
    logic [DATA_W-1:0] reload_q;
    logic [PC_W-1:0]   pcnt_q;
    logic              running;
    logic              cancel_now;
    logic              reload_now;
    logic              pulse_done;

    assign running    = (state_q == WD_RUN);
    assign cancel_now = running && !cnt_wr && act_cancel;
    assign reload_now = running && !cnt_wr && !act_cancel && act_reload;
    assign expire_evt = running && !cnt_wr && !act_cancel && !act_reload
                        && unit_tick && (count_q == 8'd1);
    assign pulse_done = (state_q == WD_FIRE) && (pcnt_q == PC_LAST);
    assign presc_restart = cnt_wr || cancel_now || reload_now;

    // count datapath
    always_comb begin
        count_nxt = count_q;
        if (cnt_wr) begin
            count_nxt = wr_data;
        end else if (cancel_now) begin
            count_nxt = '0;
        end else if (reload_now) begin
            count_nxt = reload_q;
        end else if (running && unit_tick) begin
            count_nxt = count_q - 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (cnt_wr && (wr_data != '0)) begin
                    state_nxt = WD_RUN;
                end
            end
            WD_RUN: begin
                if (cnt_wr && (wr_data == '0)) begin
                    state_nxt = WD_IDLE;
                end else if (cancel_now) begin
                    state_nxt = WD_IDLE;
                end else if (expire_evt) begin
                    state_nxt = WD_FIRE;
                end
            end
            WD_FIRE: begin
                if (pulse_done) begin
                    state_nxt = (count_nxt != '0) ? WD_RUN : WD_IDLE;
                end
            end
            default: state_nxt = WD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q  <= '0;
            reload_q <= '0;
        end else begin
            count_q <= count_nxt;
            if (cnt_wr && (wr_data != '0)) begin
                reload_q <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (state_q == WD_FIRE) begin
            pcnt_q <= pulse_done ? '0 : pcnt_q + 1'b1;
        end else begin
            pcnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        pulse_on = 1'b0;
        unique case (state_q)
            WD_IDLE: pulse_on = 1'b0;
            WD_RUN:  pulse_on = 1'b0;
            WD_FIRE: pulse_on = 1'b1;
            default: pulse_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
    import wdt_pkg::*;
#(
    parameter int CLKS_PER_SEC = 32768,
    parameter int SECS_PER_MIN = 60,
    parameter int PULSE_LEN    = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] reg_idx,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       kbd_act,
    input  logic       mouse_act,
    output logic       wdt_rst_n,
    output logic       kbrst_n
);
    wd_state_e         state_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] sts_q;
    logic              cnt_wr;
    logic              unit_tick;
    logic              expire_evt;
    logic              presc_restart;
    logic              pulse_on;
    logic              act_reload;
    logic              act_cancel;

    assign cnt_wr = wr_en && (reg_idx == IDX_COUNT);

    assign act_cancel = kbd_act && ctrl_q[CTRL_KBD_CANCEL];
    assign act_reload = (kbd_act && sts_q[STS_KBD_EN] && !ctrl_q[CTRL_KBD_CANCEL])
                        || (mouse_act && sts_q[STS_MOUSE_EN]);

    wdt_prescaler #(
        .CLKS_PER_SEC (CLKS_PER_SEC),
        .SECS_PER_MIN (SECS_PER_MIN)
    ) presc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == WD_RUN),
        .restart   (presc_restart),
        .minutes   (ctrl_q[CTRL_MINUTES]),
        .unit_tick (unit_tick)
    );

    wdt_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .reg_idx    (reg_idx),
        .wr_data    (wr_data),
        .expire_evt (expire_evt),
        .ctrl_q     (ctrl_q),
        .sts_q      (sts_q)
    );

    wdt_fsm #(
        .PULSE_LEN (PULSE_LEN)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cnt_wr        (cnt_wr),
        .wr_data       (wr_data),
        .unit_tick     (unit_tick),
        .act_reload    (act_reload),
        .act_cancel    (act_cancel),
        .state_q       (state_q),
        .count_q       (count_q),
        .expire_evt    (expire_evt),
        .presc_restart (presc_restart),
        .pulse_on      (pulse_on)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (reg_idx)
                IDX_COUNT: rd_data = count_q;
                IDX_CTRL:  rd_data = ctrl_q;
                IDX_STAT:  rd_data = sts_q;
                default:   rd_data = '0;
            endcase
        end
    end

    assign wdt_rst_n = !pulse_on;
    assign kbrst_n   = !(pulse_on && ctrl_q[CTRL_KBRST_ROUTE]);

endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [1:0] reg_idx,
    input logic [7:0] wr_data,
    input logic [7:0] count_q,
    input logic [7:0] ctrl_q,
    input logic [7:0] sts_q,
    input logic       wdt_rst_n,
    input logic       kbrst_n
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!wdt_rst_n) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assert_count_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_COUNT) |=> (count_q == $past(wr_data)));

    assert_zero_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == 8'd0 && !(wr_en && reg_idx == IDX_COUNT)) |=> (count_q == 8'd0));

    assert_fire_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_n) |-> sts_q[STS_EXPIRED]);

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_n) |-> (low_cnt == 16'(PULSE_LEN)));

    assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt <= 16'(PULSE_LEN)));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q[STS_EXPIRED] && !(wr_en && reg_idx == IDX_STAT && !wr_data[STS_EXPIRED]))
        |=> sts_q[STS_EXPIRED]);

    assert_kbrst_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !kbrst_n |-> (!wdt_rst_n && ctrl_q[CTRL_KBRST_ROUTE]));

endmodule

bind sec_watchdog sec_watchdog_chk #(
    .PULSE_LEN (PULSE_LEN)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_idx   (reg_idx),
    .wr_data   (wr_data),
    .count_q   (count_q),
    .ctrl_q    (ctrl_q),
    .sts_q     (sts_q),
    .wdt_rst_n (wdt_rst_n),
    .kbrst_n   (kbrst_n)
);

// File: tb/sec_watchdog_tb_top.sv
module sec_watchdog_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CPS        = 4;
    localparam int PLEN       = 16;
    localparam int NVEC       = 13;

    // {is_write, index, data, expected read}
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd1, 8'd1, 8'hFF, 8'h00},
        {8'd0, 8'd1, 8'h00, 8'h0E},
        {8'd1, 8'd1, 8'h00, 8'h00},
        {8'd0, 8'd1, 8'h00, 8'h00},
        {8'd1, 8'd2, 8'hFF, 8'h00},
        {8'd0, 8'd2, 8'h00, 8'hC0},
        {8'd1, 8'd2, 8'h00, 8'h00},
        {8'd0, 8'd2, 8'h00, 8'h00},
        {8'd1, 8'd3, 8'h5A, 8'h00},
        {8'd0, 8'd3, 8'h00, 8'h00},
        {8'd1, 8'd0, 8'h07, 8'h00},
        {8'd0, 8'd0, 8'h00, 8'h07},
        {8'd1, 8'd0, 8'h00, 8'h00}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] reg_idx = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       kbd_act = 1'b0;
    logic       mouse_act = 1'b0;
    logic       wdt_rst_n;
    logic       kbrst_n;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    sec_watchdog #(
        .CLKS_PER_SEC (CPS),
        .SECS_PER_MIN (60),
        .PULSE_LEN    (PLEN)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .reg_idx   (reg_idx),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .kbd_act   (kbd_act),
        .mouse_act (mouse_act),
        .wdt_rst_n (wdt_rst_n),
        .kbrst_n   (kbrst_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d);
        @(negedge clk);
        reg_idx = idx;
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [7:0] d);
        reg_idx = idx;
        rd_en = 1'b1;
        #1;
        d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic pulse_in(input bit kbd, input bit mouse);
        kbd_act = kbd;
        mouse_act = mouse;
        @(negedge clk);
        kbd_act = 1'b0;
        mouse_act = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lowc;
        int hi_bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, rv); check("R1 count", rv, 8'h00);
        rd(2'd1, rv); check("R1 ctrl", rv, 8'h00);
        rd(2'd2, rv); check("R1 status", rv, 8'h00);
        check("R1 wdt_rst_n", wdt_rst_n, 1'b1);
        check("R1 kbrst_n", kbrst_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 register map table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][31:24] != 8'd0) begin
                wr(VEC[i][17:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][17:16], rv);
                check("R2 table", rv, VEC[i][7:0]);
            end
        end

        // R3 countdown and R6/R8 expiry with routing on
        wr(2'd1, 8'h02);
        wr(2'd0, 8'd3);
        rd(2'd0, rv); check("R3 armed", rv, 8'd3);
        repeat (4) @(negedge clk);
        rd(2'd0, rv); check("R3 one unit", rv, 8'd2);
        repeat (7) @(negedge clk);
        rd(2'd0, rv); check("R3 before expiry", rv, 8'd1);
        check("R6 not yet fired", wdt_rst_n, 1'b1);
        @(negedge clk);
        check("R6 fired", wdt_rst_n, 1'b0);
        check("R8 routed", kbrst_n, 1'b0);
        rd(2'd2, rv); check("R6 status set", rv, 8'h10);
        lowc = 0;
        while (!wdt_rst_n && lowc < 100) begin
            lowc++;
            @(negedge clk);
        end
        check("R6 pulse length", lowc, PLEN);
        hi_bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!wdt_rst_n) hi_bad++;
        end
        check("R6 stays stopped", hi_bad, 0);
        rd(2'd0, rv); check("R6 count zero", rv, 8'd0);

        // R7 sticky status
        wr(2'd2, 8'h10);
        rd(2'd2, rv); check("R7 write one keeps", rv, 8'h10);
        wr(2'd2, 8'h00);
        rd(2'd2, rv); check("R7 write zero clears", rv, 8'h00);

        // R8 not routed
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd1);
        repeat (4) @(negedge clk);
        check("R8 pulse present", wdt_rst_n, 1'b0);
        check("R8 kbrst held high", kbrst_n, 1'b1);
        repeat (PLEN + 2) @(negedge clk);
        wr(2'd2, 8'h00);

        // R5 kick
        wr(2'd0, 8'd3);
        repeat (6) @(negedge clk);
        rd(2'd0, rv); check("R5 pre-kick", rv, 8'd2);
        wr(2'd0, 8'd3);
        rd(2'd0, rv); check("R5 reloaded", rv, 8'd3);
        repeat (3) @(negedge clk);
        rd(2'd0, rv); check("R5 prescaler restarted", rv, 8'd3);
        @(negedge clk);
        rd(2'd0, rv); check("R5 next unit", rv, 8'd2);

        // R4 stop
        wr(2'd0, 8'd0);
        hi_bad = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!wdt_rst_n) hi_bad++;
        end
        check("R4 no pulse", hi_bad, 0);
        rd(2'd0, rv); check("R4 count zero", rv, 8'd0);

        // R10 activity reloads
        wr(2'd2, 8'h40);
        wr(2'd0, 8'd5);
        repeat (4) @(negedge clk);
        rd(2'd0, rv); check("R10 decremented", rv, 8'd4);
        pulse_in(1'b1, 1'b0);
        rd(2'd0, rv); check("R10 keyboard reload", rv, 8'd5);
        repeat (4) @(negedge clk);
        rd(2'd0, rv); check("R10 after reload", rv, 8'd4);
        pulse_in(1'b0, 1'b1);
        rd(2'd0, rv); check("R10 mouse disabled ignored", rv, 8'd4);
        wr(2'd2, 8'hC0);
        pulse_in(1'b0, 1'b1);
        rd(2'd0, rv); check("R10 mouse reload", rv, 8'd5);

        // R11 keyboard cancel
        wr(2'd1, 8'h04);
        pulse_in(1'b1, 1'b0);
        rd(2'd0, rv); check("R11 cancel count", rv, 8'd0);
        hi_bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (!wdt_rst_n) hi_bad++;
        end
        check("R11 no pulse", hi_bad, 0);
        wr(2'd2, 8'h00);

        // R12 read strobe gating
        wr(2'd1, 8'h00);
        wr(2'd0, 8'd9);
        reg_idx = 2'd0;
        #1;
        check("R12 idle read data", rd_data, 8'h00);
        wr(2'd0, 8'd0);

        // R9 minute mode
        wr(2'd1, 8'h08);
        wr(2'd0, 8'd1);
        repeat (CPS * 60 - 1) @(negedge clk);
        rd(2'd0, rv); check("R9 one clock early", rv, 8'd1);
        check("R9 no pulse early", wdt_rst_n, 1'b1);
        @(negedge clk);
        rd(2'd0, rv); check("R9 minute elapsed", rv, 8'd0);
        check("R9 pulse", wdt_rst_n, 1'b0);
        repeat (PLEN + 2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule